// File: doc/BRIEF.md
# Preloaded Timer/Event Counter

An 8-bit up-counter with a preload register. It counts one of three sources, chosen by a two-bit mode field in a control register. In timer mode it counts ticks from an internal prescaler. In event mode it counts the active edges of an external pin. In pulse-width mode it counts prescaler ticks only while the pin holds its active level. When the counter steps past its all-ones value it reloads from the preload register. At the same edge it sets a sticky interrupt flag and raises a one-cycle wake-up request.

Software writes the preload value and the control byte through a single write port. It reads the live count on `count_o`. It starts and stops counting with `run_i`. When the counter is stopped, a preload write also lands in the counter. When the counter runs, a preload write is held back and reaches the counter only at the next overflow. Because of this, a running period can be retuned without disturbing the count that is in progress.

Top module: `tmr_preload_top`

## Requirements
- R1: After reset the count, the preload value, the interrupt flag and the wake-up output are all 0, and the mode is stopped (00).
- R2: A preload write (`wr_sel_i`=0) while the counter is not running places the written value on `count_o` at the following clock edge.
- R3: A preload write while the counter is running leaves the counter stepping as before. The written value first appears in the counter at the next overflow.
- R4: When the counter is at 0xFF and takes a count, it reloads the preload value instead of wrapping to zero, and `irq_o` goes high.
- R5: `wake_o` is high for exactly the one cycle that follows each overflow edge.
- R6: `irq_o` stays high until `irq_clr_i` is asserted. If a clear and a new overflow happen in the same cycle, the flag remains set.
- R7: In timer mode (control bits [1:0]=01) the counter advances once every 2^`psel_i` clock cycles. The first count comes 2^`psel_i` cycles after counting starts.
- R8: In event mode (bits [1:0]=10) the pin passes through two synchronising flip-flops. One count is taken for each active edge: rising edges when control bit 2 is 0, falling edges when it is 1. An edge therefore counts on the third clock edge after the pin changes.
- R9: In pulse-width mode (bits [1:0]=11) the counter advances on prescaler ticks only while the synchronised pin equals the active level: high when control bit 2 is 0, low when it is 1.
- R10: With mode 00, or with `run_i` low, the counter holds its value.
- R11: A control write that changes the mode restarts the prescaler, so the next tick comes a full 2^`psel_i` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 preload, 1 control |
| wr_data_i | input | 8 | Write data; for control, [1:0] mode and [2] polarity |
| count_o | output | 8 | Live counter value |
| pin_i | input | 1 | External event / gate pin, asynchronous |
| run_i | input | 1 | Counter enable |
| psel_i | input | 3 | Prescaler select, divide by 2^psel_i |
| irq_clr_i | input | 1 | Clear for the overflow flag |
| irq_o | output | 1 | Sticky overflow interrupt flag |
| wake_o | output | 1 | One-cycle wake-up pulse on overflow |

## Verification
The edge-detector assertion assumes the polarity bit is not rewritten at the same moment a pin edge is propagating. The stimulus writes control only while the pin has been steady for several cycles. The stimulus also changes `pin_i` on the falling clock edge and holds each level for at least four cycles, so every pin edge reaches the counter exactly once. In the same way, `psel_i` changes only while the counter is stopped or just before a mode change, so the prescaler phase the checks count from is always known.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TIMER = 2'b01,
    MODE_EVENT = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  typedef struct packed {
    logic  pol;   // 0: rising edge / high level active
    mode_e mode;
  } ctl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W  = 8,
  parameter int SEL_W = $clog2(PS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;

  assign mask   = (PS_W'(1) << sel_i) - PS_W'(1);
  assign tick_o = (div_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + PS_W'(1);
  end

  a_r11_clr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0);
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q ^ pol_i;
  assign edge_o = (s2_q ^ pol_i) & ~(prev_q ^ pol_i);

  // R8: one count per edge, never two in a row at fixed polarity
  a_r8_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && $stable(pol_i) |=> !edge_o || !$stable(pol_i));
endmodule

// File: rtl/tmr_preload_top.sv
module tmr_preload_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8,
  localparam int SEL_W = $clog2(PS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  input  logic             pin_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic             irq_clr_i,
  output logic             irq_o,
  output logic             wake_o
);
  logic [CNT_W-1:0] cnt_q, pre_q;
  ctl_t             ctl_q;
  logic             irq_q, wake_q;
  logic             running, pre_wr, ctl_wr, mode_chg, ps_clr;
  logic             tick, lvl, pin_edge, inc, wrap;

  assign running  = run_i && (ctl_q.mode != MODE_OFF);
  assign pre_wr   = wr_en_i && !wr_sel_i;
  assign ctl_wr   = wr_en_i && wr_sel_i;
  assign mode_chg = ctl_wr && (wr_data_i[1:0] != ctl_q.mode);
  assign ps_clr   = !running || mode_chg;

  tmr_prescale #(.PS_W(PS_W)) u_ps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ps_clr),
    .sel_i (psel_i),
    .tick_o(tick)
  );

  tmr_pin_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .pol_i (ctl_q.pol),
    .lvl_o (lvl),
    .edge_o(pin_edge)
  );

  always_comb begin
    unique case (ctl_q.mode)
      MODE_TIMER: inc = tick;
      MODE_EVENT: inc = pin_edge;
      MODE_PULSE: inc = tick && lvl;
      default:    inc = 1'b0;
    endcase
  end

  assign wrap = running && inc && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      ctl_q  <= '{pol: 1'b0, mode: MODE_OFF};
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (pre_wr) pre_q <= wr_data_i;
      if (ctl_wr) begin
        ctl_q.mode <= mode_e'(wr_data_i[1:0]);
        ctl_q.pol  <= wr_data_i[2];
      end
      // stopped: direct load; running: preload waits for overflow
      if (pre_wr && !running)   cnt_q <= wr_data_i;
      else if (running && inc)  cnt_q <= wrap ? pre_q : cnt_q + CNT_W'(1);
      if (wrap)                 irq_q <= 1'b1;
      else if (irq_clr_i)       irq_q <= 1'b0;
      wake_q <= wrap;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign wake_o  = wake_q;

  a_r2_stopped_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wr && !running |=> count_o == $past(wr_data_i));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> count_o == $past(pre_q) && irq_o);
  a_r5_wake_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);
  a_r6_clr_vs_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap && irq_clr_i |=> irq_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running && !pre_wr |=> $stable(count_o));
endmodule

// File: tb/sim_tmr_preload_top.sv
module sim_tmr_preload_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] count_o;
  logic       pin_i = 1'b0, run_i = 1'b0, irq_clr_i = 1'b0;
  logic [2:0] psel_i = '0;
  logic       irq_o, wake_o;
  int         total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_preload_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .count_o(count_o), .pin_i(pin_i), .run_i(run_i),
    .psel_i(psel_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr_i = 1'b1; tick(1); irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 wake", {7'd0, wake_o}, 8'h00);
    run_i = 1'b1; tick(5);
    chk("R1 mode off holds", count_o, 8'h00);
    run_i = 1'b0;
  endtask

  task automatic t_stopped_load();
    wr(1'b0, 8'h37);
    chk("R2 direct load", count_o, 8'h37);
    run_i = 1'b1; tick(4);
    chk("R10 mode 00 holds", count_o, 8'h37);
    run_i = 1'b0;
    wr(1'b1, 8'h01);
    tick(4);
    chk("R10 run low holds", count_o, 8'h37);
  endtask

  task automatic t_timer_ovf();
    psel_i = 3'd0;
    wr(1'b0, 8'hFA);
    run_i = 1'b1;
    tick(3); chk("R7 div1 count", count_o, 8'hFD);
    tick(2); chk("R4 at ff", count_o, 8'hFF);
    chk("R4 irq low before", {7'd0, irq_o}, 8'h00);
    tick(1);
    chk("R4 reload", count_o, 8'hFA);
    chk("R4 irq set", {7'd0, irq_o}, 8'h01);
    chk("R5 wake high", {7'd0, wake_o}, 8'h01);
    tick(1);
    chk("R5 wake one cycle", {7'd0, wake_o}, 8'h00);
    chk("R6 irq sticky", {7'd0, irq_o}, 8'h01);
    run_i = 1'b0;
    clr_irq();
    chk("R6 cleared", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_timer_div4();
    wr(1'b0, 8'h10);
    psel_i = 3'd2; run_i = 1'b1;
    tick(3); chk("R7 div4 early", count_o, 8'h10);
    tick(1); chk("R7 div4 first", count_o, 8'h11);
    tick(4); chk("R7 div4 second", count_o, 8'h12);
    run_i = 1'b0;
  endtask

  task automatic t_running_preload();
    psel_i = 3'd0;
    wr(1'b0, 8'hF0);
    run_i = 1'b1;
    tick(2); chk("R3 before", count_o, 8'hF2);
    wr(1'b0, 8'h80);
    chk("R3 count undisturbed", count_o, 8'hF3);
    tick(12); chk("R3 reaches ff", count_o, 8'hFF);
    tick(1); chk("R3 new preload at ovf", count_o, 8'h80);
    run_i = 1'b0;
    clr_irq();
  endtask

  task automatic t_clr_collision();
    wr(1'b0, 8'hFE);
    run_i = 1'b1;
    tick(2);
    chk("R6 first ovf", {7'd0, irq_o}, 8'h01);
    tick(1);
    irq_clr_i = 1'b1; tick(1); irq_clr_i = 1'b0;
    chk("R6 clear loses to ovf", {7'd0, irq_o}, 8'h01);
    run_i = 1'b0;
    clr_irq();
    chk("R6 clear alone", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_mode_change();
    pin_i = 1'b1;
    wr(1'b0, 8'h20);
    psel_i = 3'd2; run_i = 1'b1;
    tick(2);
    wr(1'b1, 8'h03);  // timer -> pulse width, high active
    tick(3); chk("R11 prescaler restarted", count_o, 8'h20);
    tick(1); chk("R11 first tick after change", count_o, 8'h21);
    run_i = 1'b0;
  endtask

  task automatic t_pulse();
    psel_i = 3'd0;
    pin_i = 1'b0; tick(4);
    wr(1'b0, 8'h40);
    run_i = 1'b1;
    tick(5); chk("R9 gated off", count_o, 8'h40);
    pin_i = 1'b1;
    tick(2); chk("R9 sync delay", count_o, 8'h40);
    tick(3); chk("R9 counting high", count_o, 8'h43);
    pin_i = 1'b0;
    tick(5); chk("R9 stop after low", count_o, 8'h45);
    wr(1'b1, 8'h07);  // low active
    tick(4); chk("R9 low active", count_o, 8'h49);
    run_i = 1'b0;
  endtask

  task automatic t_event();
    psel_i = 3'd3;
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h00);
    run_i = 1'b1;
    pin_i = 1'b1; tick(2);
    chk("R8 not yet synced", count_o, 8'h00);
    tick(2); chk("R8 rising counted", count_o, 8'h01);
    pin_i = 1'b0; tick(4);
    chk("R8 falling ignored", count_o, 8'h01);
    for (int i = 0; i < 2; i++) begin
      pin_i = 1'b1; tick(4); pin_i = 1'b0; tick(4);
    end
    chk("R8 three rising", count_o, 8'h03);
    wr(1'b1, 8'h06);
    pin_i = 1'b1; tick(4);
    chk("R8 rising ignored when falling set", count_o, 8'h03);
    pin_i = 1'b0; tick(4);
    chk("R8 falling counted", count_o, 8'h04);
    run_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_stopped_load();
    t_timer_ovf();
    t_timer_div4();
    t_running_preload();
    t_clr_collision();
    t_mode_change();
    t_pulse();
    t_event();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule